// File: doc/BRIEF.md
# Offset Programmable Clock Divider

This block divides its input clock by a ratio chosen at run time. Software loads a 10-bit ratio field as two bytes from an upstream serial controller. The divide ratio is the field value plus two, so any ratio from 2 to 1025 can be reached.

Each byte comes with a valid strobe and a flag that marks it as the leading byte or the trailing byte. The leading byte carries the upper eight bits of the field. The two top bits of the trailing byte complete the field, and the rest of that byte is ignored. The assembled value waits in a holding register. It reaches the counter only when the current output period ends, so no period is ever cut short.

The block has two outputs. One is a divided clock. Its high phase is half the period, rounded up for odd ratios. The other is a one-cycle tick that marks the first input cycle of every output period. Downstream logic can use the tick as a clock enable.

Top module: `cdv_offset_div`

## Requirements
- R1: After reset the field is 0 and the ratio is 2. While reset is held, `div_clk` and `div_tick` are both 1.
- R2: Each output period lasts field+2 input clock cycles.
- R3: `div_clk` is high for ceil(ratio/2) cycles and then low for floor(ratio/2) cycles. For odd ratios the high phase is therefore one cycle longer.
- R4: `div_tick` is 1 for exactly one cycle per period: the first cycle, in which `div_clk` rises.
- R5: A byte with `byte_second`=0 supplies field bits 9..2, with byte bit 7 as field bit 9.
- R6: A byte with `byte_second`=1 supplies field bits 1..0 from its bits 7..6. Its bits 5..0 have no effect.
- R7: A leading byte on its own does not change the ratio.
- R8: A trailing byte that arrives with no leading byte stored since the last completed pair is ignored.
- R9: An assembled field takes effect on the first period boundary after it is stored. The period in progress ends at its old length.
- R10: A second leading byte, sent before the trailing byte, replaces the upper bits stored by the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | One-cycle strobe: a ratio byte is present |
| byte_second | input | 1 | 0 = leading byte, 1 = trailing byte |
| byte_data | input | 8 | Ratio byte contents |
| div_clk | output | 1 | Divided clock |
| div_tick | output | 1 | Pulse in the first input cycle of each output period |

## Verification
On every cycle, the in-RTL assertions check four things. The phase counter stays below the active ratio. The tick lines up with the high phase. The falling edge lands at the computed half point. The active ratio changes only when the counter wraps to zero. They also check that a leading byte, or an unpaired trailing byte, leaves the holding register untouched.

Some properties need the bench's scenarios. These are the bit packing across the two bytes, the exact high and low lengths at the smallest, odd and largest ratios, and the replacement of stored upper bits. A behavioural model in the bench compares both outputs on every cycle, and the scenarios measure the phase lengths directly.

// File: rtl/cdv_pkg.sv
package cdv_pkg;
   // number of cycles the divided clock stays high for a given ratio
   function automatic int unsigned high_phase(input int unsigned ratio);
      return (ratio + 1) / 2;
   endfunction
endpackage

// File: rtl/cdv_byte_asm.sv
module cdv_byte_asm #(
   parameter int BYTE_W  = 8,
   parameter int FIELD_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               byte_vld,
   input  logic               byte_second,
   input  logic [BYTE_W-1:0]  byte_data,
   input  logic               take,
   output logic               pend_vld,
   output logic [FIELD_W-1:0] pend_field
);
   localparam int LO_W = FIELD_W - BYTE_W;

   generate
      if (LO_W < 1 || LO_W > BYTE_W) begin : g_bad_split
         $error("cdv_byte_asm: FIELD_W must exceed BYTE_W by 1..BYTE_W");
      end
   endgenerate

   logic [BYTE_W-1:0]  hi_q;
   logic               have_hi_q;
   logic [LO_W-1:0]    lo_bits;
   logic               load_first, load_pair;

   // the low field bits sit left-justified in the trailing byte
   generate
      if (LO_W == BYTE_W) begin : g_full_lo
         assign lo_bits = byte_data;
      end else begin : g_part_lo
         assign lo_bits = byte_data[BYTE_W-1 -: LO_W];
      end
   endgenerate

   assign load_first = byte_vld && !byte_second;
   assign load_pair  = byte_vld &&  byte_second && have_hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q       <= '0;
         have_hi_q  <= 1'b0;
         pend_vld   <= 1'b0;
         pend_field <= '0;
      end else begin
         if (load_first) begin
            hi_q      <= byte_data;
            have_hi_q <= 1'b1;
         end else if (load_pair) begin
            have_hi_q <= 1'b0;
         end
         if (load_pair) begin
            pend_field <= {hi_q, lo_bits};
            pend_vld   <= 1'b1;
         end else if (take) begin
            pend_vld   <= 1'b0;
         end
      end
   end

   // R7: a leading byte never disturbs the holding register
   p_first_no_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      load_first |=> $stable(pend_field));
   // R8: an unpaired trailing byte is dropped
   p_lone_second_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && byte_second && !have_hi_q) |=> $stable(pend_field));
endmodule

// File: rtl/cdv_period_ctr.sv
module cdv_period_ctr #(
   parameter int FIELD_W = 10,
   parameter int OFFSET  = 2,
   parameter int CNT_W   = 11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pend_vld,
   input  logic [FIELD_W-1:0] pend_field,
   output logic               take,
   output logic               div_clk,
   output logic               div_tick
);
   import cdv_pkg::*;

   logic [CNT_W-1:0] cnt_q, div_q;
   logic [CNT_W:0]   hi_len;
   logic             last;

   assign last    = (cnt_q == div_q - 1'b1);
   assign take    = last && pend_vld;
   assign hi_len  = (CNT_W+1)'(high_phase(int'(div_q)));
   assign div_clk = ({1'b0, cnt_q} < hi_len);
   assign div_tick = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         div_q <= CNT_W'(OFFSET);
      end else begin
         cnt_q <= last ? '0 : cnt_q + 1'b1;
         if (take) div_q <= CNT_W'(pend_field) + CNT_W'(OFFSET);
      end
   end

   p_cnt_below_div_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < div_q);
   p_div_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
      div_q >= CNT_W'(OFFSET));
   p_tick_in_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      div_tick |-> div_clk);
   p_fall_at_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(div_clk) |-> ({1'b0, cnt_q} == hi_len));
   p_ratio_at_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(div_q) |-> (cnt_q == '0));
endmodule

// File: rtl/cdv_offset_div.sv
module cdv_offset_div #(
   parameter int BYTE_W  = 8,
   parameter int FIELD_W = 10,
   parameter int OFFSET  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_vld,
   input  logic              byte_second,
   input  logic [BYTE_W-1:0] byte_data,
   output logic              div_clk,
   output logic              div_tick
);
   localparam int MAX_DIV = (1 << FIELD_W) - 1 + OFFSET;
   localparam int CNT_W   = $clog2(MAX_DIV + 1);

   generate
      if (OFFSET < 2) begin : g_bad_offset
         $error("cdv_offset_div: OFFSET below 2 cannot form two phases");
      end
   endgenerate

   logic               take, pend_vld;
   logic [FIELD_W-1:0] pend_field;

   cdv_byte_asm #(.BYTE_W(BYTE_W), .FIELD_W(FIELD_W)) u_asm (
      .clk(clk), .rst_n(rst_n),
      .byte_vld(byte_vld), .byte_second(byte_second), .byte_data(byte_data),
      .take(take), .pend_vld(pend_vld), .pend_field(pend_field));

   cdv_period_ctr #(.FIELD_W(FIELD_W), .OFFSET(OFFSET), .CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n),
      .pend_vld(pend_vld), .pend_field(pend_field),
      .take(take), .div_clk(div_clk), .div_tick(div_tick));
endmodule

// File: tb/tb_cdv_offset_div.sv
`timescale 1ns/1ps
module tb_cdv_offset_div;
   logic clk = 1'b0, rst_n = 1'b0;
   logic byte_vld = 1'b0, byte_second = 1'b0;
   logic [7:0] byte_data = '0;
   logic div_clk, div_tick;

   int errors = 0, checks = 0;
   bit done = 1'b0;

   // behavioural reference state
   int m_hi = 0, m_pend = 0, m_div = 2, m_cnt = 0;
   bit m_have = 0, m_pvld = 0;

   always #4 clk = ~clk;

   cdv_offset_div dut (.clk(clk), .rst_n(rst_n), .byte_vld(byte_vld),
      .byte_second(byte_second), .byte_data(byte_data),
      .div_clk(div_clk), .div_tick(div_tick));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_edge(input bit v, input bit s, input int d);
      bit last, apply;
      if (!rst_n) begin
         m_hi = 0; m_have = 0; m_pend = 0; m_pvld = 0; m_div = 2; m_cnt = 0;
         return;
      end
      last  = (m_cnt == m_div - 1);
      apply = last && m_pvld;
      if (apply) m_div = m_pend + 2;
      m_cnt = last ? 0 : m_cnt + 1;
      if (v && !s) begin
         m_hi = d; m_have = 1;
      end else if (v && s && m_have) begin
         m_pend = m_hi * 4 + (d >> 6); m_pvld = 1; m_have = 0;
      end else if (apply) m_pvld = 0;
   endtask

   // one input cycle: drive, pass a rising edge, update model, compare
   task automatic step(input bit v, input bit s, input int d);
      byte_vld = v; byte_second = s; byte_data = 8'(d);
      @(negedge clk);
      model_edge(v, s, d);
      check(div_clk == (m_cnt < (m_div + 1) / 2), "R2/R3 div_clk", div_clk, m_cnt < (m_div + 1) / 2);
      check(div_tick == (m_cnt == 0), "R4 div_tick", div_tick, m_cnt == 0);
      byte_vld = 0; byte_second = 0; byte_data = '0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0);
   endtask

   task automatic to_tick();
      step(0, 0, 0);
      while (!div_tick) step(0, 0, 0);
   endtask

   task automatic measure(input int hi, input int lo, input string tag);
      int h, l;
      to_tick(); to_tick();
      h = 1; l = 0;
      step(0, 0, 0);
      while (div_clk && !div_tick) begin h++; step(0, 0, 0); end
      while (!div_clk) begin l++; step(0, 0, 0); end
      check(h == hi, {tag, " high phase"}, h, hi);
      check(l == lo, {tag, " low phase"}, l, lo);
      check(div_tick == 1, {tag, " tick at period start"}, div_tick, 1);
   endtask

   task automatic write_pair(input int b0, input int b1);
      step(1, 0, b0);
      step(1, 1, b1);
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(div_clk == 1, "R1 reset div_clk", div_clk, 1);
      check(div_tick == 1, "R1 reset div_tick", div_tick, 1);
      rst_n = 1'b1;
      measure(1, 1, "R1 default ratio 2");

      // R5 R6: field 5 from 0x01 then 0x7F (junk low bits) -> ratio 7
      write_pair(8'h01, 8'h7F);
      measure(4, 3, "R5 R6 R3 ratio 7");

      // R7: leading byte alone keeps ratio 7
      step(1, 0, 8'hFF);
      idle(20);
      measure(4, 3, "R7 lone leading byte");

      // R10: new leading byte replaces 0xFF; field 2 -> ratio 4
      step(1, 0, 8'h00);
      step(1, 1, 8'h80);
      measure(2, 2, "R10 replaced upper bits");

      // R8: unpaired trailing byte ignored
      step(1, 1, 8'hC0);
      idle(10);
      measure(2, 2, "R8 unpaired trailing byte");

      // R9: write mid-period on a long ratio, old period completes
      write_pair(8'h00, 8'h40);   // field 1 -> ratio 3
      measure(2, 1, "R9 R3 odd ratio 3");
      write_pair(8'h02, 8'h00);   // field 8 -> ratio 10
      idle(3);
      write_pair(8'h00, 8'h00);   // ratio 2 issued mid-period
      idle(30);
      measure(1, 1, "R9 R2 back to ratio 2");

      // R2: largest ratio 1025
      write_pair(8'hFF, 8'hC0);
      measure(513, 512, "R2 ratio 1025");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule